// File: doc/BRIEF.md
# Fractional Dithering DAC Code Sequencer

This block lets a plain 8-bit DAC resolve steps finer than one LSB. The target is a fixed-point value with an 8-bit integer part and a 4-bit fractional part. On every update strobe the block emits an 8-bit code. That code is either the integer part or the next code up. Over a period of 16 updates, the number of upper-code samples equals the fractional part. The time-averaged DAC output therefore lands between two adjacent steps, with a resolution of 1/16 LSB.

A first-order phase accumulator picks which updates use the upper code. The accumulator is cleared at the start of each period. On each strobe the fraction is added to it, and a carry out of the addition selects the upper code. This spreads the upper samples evenly across the period instead of grouping them together. A target is taken only at the first update of a period, so one period never mixes two targets. The code and its valid flag are registered.

Top module: `dither_dac_seq`

## Requirements
- R1: Every emitted code equals the latched integer part N or N+1. No other code value appears.
- R2: Within one period of 16 updates, the number of updates that emit the upper code equals the 4-bit fraction F, read as F/16 LSB. For example, F=4 gives 4 of 16 updates and F=8 gives 8 of 16.
- R3: Number the updates of a period k=1..16. Update k emits the upper code exactly when floor(k*F/16) > floor((k-1)*F/16).
- R4: With F=0, every update emits the integer code N.
- R5: With N=255 and F nonzero, the upper code saturates at 255 and never wraps to 0.
- R6: The target inputs are sampled only on the first strobe of a period. Changes on later strobes of that period have no effect until 16 strobes after the period began.
- R7: dac_code and code_valid change one clock after a strobe. code_valid is high for exactly one cycle per strobe. dac_code holds its value between strobes.
- R8: Synchronous active-high reset sets dac_code to 0 and code_valid to 0. It also clears the phase, so the next strobe is update 1 of a fresh period.
- R9: When N<255, the 16 codes of one period sum to exactly 16*N+F, so their average equals the fixed-point target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Update strobe, one update per high cycle |
| target_int | input | 8 | Integer part N of the target |
| target_frac | input | 4 | Fractional part F of the target, in 1/16 LSB |
| dac_code | output | 8 | Registered DAC code |
| code_valid | output | 1 | High for one cycle after each strobe |

## Verification
Full periods are run with fractions 1, 4, 8, 11 and 15. Fractions 4 and 8 confirm the quarter and half duty cases. The odd fractions 1, 11 and 15 separate evenly spread placement from a burst or from a count that is off by one. The F=0 pattern checks that no carry ever occurs. An N=255 period exposes wrap-around to 0.

A target change in the middle of a period tells late latching apart from latching at the period start. Strobes with idle gaps between them check the valid pulse and that the code holds. A reset in the middle of a period checks that the phase restarts from zero.

// File: rtl/dither_pkg.sv
package dither_pkg;
  localparam int CODE_W = 8;
  localparam int FRAC_W = 4;
  localparam int PERIOD = 1 << FRAC_W;

  // Saturating increment of a DAC code.
  function automatic logic [CODE_W-1:0] code_up(input logic [CODE_W-1:0] c);
    if (c == {CODE_W{1'b1}}) return c;
    return c + 1'b1;
  endfunction

  // Accumulator step: returns {carry, new phase}.
  function automatic logic [FRAC_W:0] phase_add(input logic [FRAC_W-1:0] ph,
                                                input logic [FRAC_W-1:0] fr);
    return {1'b0, ph} + {1'b0, fr};
  endfunction

  // Code choice from carry.
  function automatic logic [CODE_W-1:0] pick_code(input logic [CODE_W-1:0] base,
                                                  input logic upper);
    return upper ? code_up(base) : base;
  endfunction
endpackage

// File: rtl/dither_slot_ctr.sv
module dither_slot_ctr #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  output logic [FRAC_W-1:0] slot_idx,
  output logic              slot_first
);
  always_ff @(posedge clk) begin
    if (rst) slot_idx <= '0;
    else if (step_en) slot_idx <= slot_idx + 1'b1;
  end

  assign slot_first = (slot_idx == '0);
endmodule

// File: rtl/dither_phase_acc.sv
module dither_phase_acc
  import dither_pkg::*;
#(
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          restart,
  input  logic [FW-1:0] frac,
  output logic          carry
);
  logic [FW-1:0] phase_q;
  logic [FW-1:0] phase_in;
  logic [FW:0]   sum;

  assign phase_in = restart ? '0 : phase_q;
  assign sum      = {1'b0, phase_in} + {1'b0, frac};
  assign carry    = sum[FW];

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (step_en) phase_q <= sum[FW-1:0];
  end
endmodule

// File: rtl/dither_code_sel.sv
module dither_code_sel
  import dither_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] base_code,
  input  logic          upper,
  output logic [CW-1:0] code_next
);
  always_comb begin
    if (upper && base_code != {CW{1'b1}}) code_next = base_code + 1'b1;
    else                                  code_next = base_code;
  end
endmodule

// File: rtl/dither_dac_seq.sv
module dither_dac_seq
  import dither_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [CODE_W-1:0] target_int,
  input  logic [FRAC_W-1:0] target_frac,
  output logic [CODE_W-1:0] dac_code,
  output logic              code_valid
);
  logic [FRAC_W-1:0] slot_idx;
  logic              upd_restart;
  logic              upd_fire;
  logic              upd_upper;
  logic [CODE_W-1:0] held_int;
  logic [FRAC_W-1:0] held_frac;
  logic [CODE_W-1:0] eff_int;
  logic [FRAC_W-1:0] eff_frac;
  logic [CODE_W-1:0] code_next;

  assign upd_fire = step_en;

  dither_slot_ctr #(.FRAC_W(FRAC_W)) u_slot (
    .clk(clk), .rst(rst), .step_en(upd_fire),
    .slot_idx(slot_idx), .slot_first(upd_restart)
  );

  // Inputs pass straight through on the first update of a period.
  assign eff_int  = upd_restart ? target_int  : held_int;
  assign eff_frac = upd_restart ? target_frac : held_frac;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_int  <= '0;
      held_frac <= '0;
    end else if (upd_fire && upd_restart) begin
      held_int  <= target_int;
      held_frac <= target_frac;
    end
  end

  dither_phase_acc #(.FW(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .step_en(upd_fire), .restart(upd_restart),
    .frac(eff_frac), .carry(upd_upper)
  );

  dither_code_sel #(.CW(CODE_W)) u_sel (
    .base_code(eff_int), .upper(upd_upper), .code_next(code_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code   <= '0;
      code_valid <= 1'b0;
    end else begin
      code_valid <= upd_fire;
      if (upd_fire) dac_code <= code_next;
    end
  end
endmodule

// File: rtl/dither_dac_seq_chk.sv
module dither_dac_seq_chk
  import dither_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              upd_fire,
  input logic              upd_restart,
  input logic              upd_upper,
  input logic [FRAC_W-1:0] slot_idx,
  input logic [CODE_W-1:0] eff_int,
  input logic [FRAC_W-1:0] eff_frac,
  input logic [CODE_W-1:0] held_int,
  input logic [FRAC_W-1:0] held_frac,
  input logic [CODE_W-1:0] dac_code,
  input logic              code_valid
);
  logic [FRAC_W:0] up_cnt;

  always_ff @(posedge clk) begin
    if (rst) up_cnt <= '0;
    else if (upd_fire)
      up_cnt <= upd_restart ? {{FRAC_W{1'b0}}, upd_upper}
                            : up_cnt + {{FRAC_W{1'b0}}, upd_upper};
  end

  // R7: valid tracks the strobe one clock later
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> code_valid);
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !upd_fire |=> !code_valid && $stable(dac_code));

  // R1: code is base or base plus one
  a_r1_adjacent: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> (dac_code == $past(eff_int)) || (dac_code == $past(eff_int) + 8'd1));

  // R4: zero fraction never carries
  a_r4_zero_frac: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && eff_frac == '0) |-> !upd_upper);

  // R5: top code never wraps
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && eff_int == {CODE_W{1'b1}}) |=> dac_code == {CODE_W{1'b1}});

  // R6: target held through a period
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !(upd_fire && upd_restart) |=> $stable(held_int) && $stable(held_frac));

  // R2: upper count over a period equals the fraction
  a_r2_count: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && slot_idx == {FRAC_W{1'b1}}) |->
      (up_cnt + {{FRAC_W{1'b0}}, upd_upper}) == {1'b0, eff_frac});
endmodule

bind dither_dac_seq dither_dac_seq_chk u_chk (
  .clk(clk), .rst(rst), .upd_fire(upd_fire), .upd_restart(upd_restart),
  .upd_upper(upd_upper), .slot_idx(slot_idx), .eff_int(eff_int),
  .eff_frac(eff_frac), .held_int(held_int), .held_frac(held_frac),
  .dac_code(dac_code), .code_valid(code_valid)
);

// File: tb/dither_dac_seq_bench.sv
module dither_dac_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic [7:0] target_int = '0;
  logic [3:0] target_frac = '0;
  logic [7:0] dac_code;
  logic       code_valid;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  dither_dac_seq u_dither_dac_seq (
    .clk(clk), .rst(rst), .step_en(step_en), .target_int(target_int),
    .target_frac(target_frac), .dac_code(dac_code), .code_valid(code_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: update k (1..16) of a period is upper when k*F crosses a multiple of 16.
  function automatic bit ref_upper(input int k, input int f);
    return ((k * f) / 16) != (((k - 1) * f) / 16);
  endfunction

  function automatic int ref_code(input int n, input int f, input int k);
    int c;
    c = ref_upper(k, f) ? n + 1 : n;
    return (c > 255) ? 255 : c;
  endfunction

  // One strobe; returns code seen one clock later.
  task automatic strobe(output int code);
    @(negedge clk); step_en = 1'b1;
    @(negedge clk); step_en = 1'b0;
    check("R7 valid", code_valid, 1);
    code = dac_code;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R8 code after reset", dac_code, 0);
    check("R8 valid after reset", code_valid, 0);
  endtask

  task automatic t_period(input int n, input int f);
    int sum = 0;
    int ups = 0;
    int c;
    target_int = n[7:0]; target_frac = f[3:0];
    for (int k = 1; k <= 16; k++) begin
      strobe(c);
      check($sformatf("R3 N=%0d F=%0d k=%0d", n, f, k), c, ref_code(n, f, k));
      check("R1 adjacent", int'(c == n || c == n + 1), 1);
      sum += c;
      if (c != n) ups++;
    end
    check($sformatf("R2 upper count F=%0d", f), ups, f);
    if (n < 255) check($sformatf("R9 sum N=%0d F=%0d", n, f), sum, 16 * n + f);
  endtask

  task automatic t_zero_frac();
    int c;
    target_int = 8'd77; target_frac = 4'd0;
    for (int k = 1; k <= 16; k++) begin
      strobe(c);
      check("R4 zero fraction", c, 77);
    end
  endtask

  task automatic t_saturate();
    int c;
    target_int = 8'd255; target_frac = 4'd9;
    for (int k = 1; k <= 16; k++) begin
      strobe(c);
      check("R5 saturation", c, 255);
    end
  endtask

  task automatic t_midchange();
    int c;
    target_int = 8'd10; target_frac = 4'd8;
    for (int k = 1; k <= 16; k++) begin
      strobe(c);
      if (k == 3) begin target_int = 8'd50; target_frac = 4'd0; end
      check($sformatf("R6 old target k=%0d", k), c, ref_code(10, 8, k));
    end
    strobe(c);
    check("R6 new target at period start", c, 50);
    for (int k = 2; k <= 16; k++) strobe(c);
  endtask

  task automatic t_gaps();
    int c;
    target_int = 8'd20; target_frac = 4'd15;
    strobe(c);
    repeat (3) @(negedge clk);
    check("R7 valid low when idle", code_valid, 0);
    check("R7 code held", dac_code, c);
    for (int k = 2; k <= 16; k++) begin
      strobe(c);
      check("R7 gapped pattern", c, ref_code(20, 15, k));
      @(negedge clk);
    end
  endtask

  task automatic t_reset_mid();
    int c;
    target_int = 8'd30; target_frac = 4'd4;
    for (int k = 1; k <= 5; k++) strobe(c);
    do_reset();
    check("R8 code cleared mid period", dac_code, 0);
    target_int = 8'd40; target_frac = 4'd5;
    for (int k = 1; k <= 16; k++) begin
      strobe(c);
      check($sformatf("R8 restart k=%0d", k), c, ref_code(40, 5, k));
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_period(100, 4);
    t_period(100, 8);
    t_period(3, 1);
    t_period(200, 11);
    t_period(0, 15);
    t_zero_frac();
    t_saturate();
    t_period(254, 15);
    t_midchange();
    t_gaps();
    t_reset_mid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule